// File: doc/BRIEF.md
# AGP Pipelined Read Request Issuer

This block sits between an internal read consumer and the AGP address phase of a graphics bus master. It takes one read job at a time, described by a doubleword-aligned address, a byte count and an urgency hint. It turns the job into one or more pipelined address requests. To get the bus it lowers an active-low bus request and waits for the arbiter's start grant. It then enqueues one request per clock with the active-low pipe strobe. Each enqueued request carries its address, a length code and a read command.

Reads of 64 bytes or less go out as a single request. Longer reads are cut into 32-byte pieces. The block counts the requests whose data has not yet come back and never lets that count pass four. When the count is about to reach the cap, or when the job's last piece is sent, the block marks that request as the final one of the window by raising the bus request in the same clock. Completions pulsed in from the data-reply side lower the count. The block then asks for the bus again to keep the pipe full, even while reply data is still flowing.

Top module: `agp_rd_issuer`

## Requirements
- R1: `rd_ready` is high exactly when no job is held; a job is taken on a clock where `rd_valid` and `rd_ready` are both high, and `rd_ready` stays low until its last piece has been issued.
- R2: After a job is taken while fewer than four reads are outstanding, `bus_req_n` goes low in the second clock after acceptance and stays low until the final request of the window.
- R3: A start grant is `gnt_n` low together with `st` equal to 3'b111; `pipe_n` goes low in the clock after a start grant is sampled, and a grant with any other `st` value does not start issuing.
- R4: In an enqueue clock, `ad[31:3]` carries the request address and `ad[2:0]` carries the length code (bytes/8 − 1). `cbe_n` carries the inverted command, with 4'b0000 for a low-priority read and 4'b0100 for a high-priority read. Outside enqueue clocks `pipe_n` is 1, `ad` is 0 and `cbe_n` is 4'hF.
- R5: Within a grant window one request is enqueued on every consecutive clock, and the final request of the window is marked by `bus_req_n` high in the same clock as `pipe_n` low.
- R6: A job of 64 bytes or less is issued as one request. A longer job is issued as consecutive 32-byte pieces with the address advancing by 32 each time, and a smaller remainder goes last.
- R7: The command of each request reflects `rd_hi_pri` in the clock in which that request is enqueued.
- R8: `pend_cnt` rises by one for every enqueued request and falls by one for every `reply_done` pulse. Both may happen in the same clock.
- R9: `pend_cnt` never exceeds 4. The request that brings it to 4 is marked final, and no request is enqueued while it is 4. After a completion the block requests the bus again and continues the job.
- R10: A `reply_done` pulse while `pend_cnt` is 0 is ignored and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read job offered |
| rd_ready | output | 1 | Block can take a job |
| rd_dw_addr | input | 29 | Job start address, 8-byte units (address bits 31:3) |
| rd_bytes | input | 9 | Job length in bytes, a multiple of 8 from 8 to 256 |
| rd_hi_pri | input | 1 | Consumer expects a latency stall; issue high priority |
| bus_req_n | output | 1 | Active-low bus request |
| gnt_n | input | 1 | Active-low bus grant |
| st | input | 3 | Arbiter status code |
| pipe_n | output | 1 | Active-low pipe strobe, one request per low clock |
| ad | output | 32 | Request address and length code |
| cbe_n | output | 4 | Active-low command lines |
| reply_done | input | 1 | One pulse per completed data reply |
| pend_cnt | output | 3 | Number of outstanding read requests |

## Verification
The hardest state to reach from the ports is the cap. A single job must fill the pipe to four outstanding reads, stop on a final-marked request, and then restart from a lone completion while still holding the rest of its pieces. The stimulus reaches it with a 256-byte job and a completion side that is held silent, so that eight 32-byte pieces pile up against the limit. One completion is then released at a time, and the bench observes each new single-request window. The arbiter model re-grants on every request, so each cap-induced stop and re-request shows up as a separate window at the pins.

// File: rtl/agp_rq_pkg.sv
package agp_rq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_REQ   = 2'd1,
    SQ_ISSUE = 2'd2
  } sq_state_t;

  localparam logic [2:0] ST_START  = 3'b111;
  localparam logic [3:0] CMD_RD_LO = 4'b0000;
  localparam logic [3:0] CMD_RD_HI = 4'b0100;

  // Length code: number of 8-byte units minus one.
  function automatic logic [2:0] len_code(input logic [15:0] nbytes);
    logic [15:0] units;
    units = (nbytes >> 3) - 16'd1;
    return units[2:0];
  endfunction

  // Read command before inversion onto the active-low lines.
  function automatic logic [3:0] rd_cmd(input logic hi);
    return hi ? CMD_RD_HI : CMD_RD_LO;
  endfunction

endpackage

// File: rtl/agp_rq_split.sv
module agp_rq_split #(
  parameter int BYTES_W      = 9,
  parameter int PIECE_BYTES  = 32,
  parameter int SPLIT_ABOVE  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_i,
  input  logic [31:3]        addr_i,
  input  logic [BYTES_W-1:0] bytes_i,
  input  logic               adv_i,
  output logic               busy_o,
  output logic [31:3]        cur_addr_o,
  output logic [2:0]         cur_len_o,
  output logic               cur_last_o
);
  import agp_rq_pkg::*;

  localparam logic [BYTES_W-1:0] PIECE_V = BYTES_W'(PIECE_BYTES);
  localparam logic [BYTES_W-1:0] SPLIT_V = BYTES_W'(SPLIT_ABOVE);

  logic               busy_q;
  logic [31:3]        addr_q;
  logic [BYTES_W-1:0] remain_q;
  logic               split_q;
  logic [BYTES_W-1:0] piece;

  always_comb begin
    if (split_q && (remain_q > PIECE_V)) piece = PIECE_V;
    else                                 piece = remain_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      split_q  <= 1'b0;
    end else if (acc_i && !busy_q) begin
      busy_q   <= 1'b1;
      addr_q   <= addr_i;
      remain_q <= bytes_i;
      split_q  <= (bytes_i > SPLIT_V);
    end else if (adv_i && busy_q) begin
      addr_q   <= addr_q + 29'(piece >> 3);
      remain_q <= remain_q - piece;
      if (remain_q == piece) busy_q <= 1'b0;
    end
  end

  assign busy_o     = busy_q;
  assign cur_addr_o = addr_q;
  assign cur_len_o  = len_code(16'(piece));
  assign cur_last_o = (remain_q == piece);

endmodule

// File: rtl/agp_rq_credit.sv
module agp_rq_credit #(
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             near_full_o
);
  localparam logic [CNT_W-1:0] CAP_V  = CNT_W'(MAX_OUT);
  localparam logic [CNT_W-1:0] NEAR_V = CNT_W'(MAX_OUT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic up, dn;

  assign up = inc_i && (cnt_q != CAP_V);
  assign dn = dec_i && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      case ({up, dn})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o       = cnt_q;
  assign full_o      = (cnt_q == CAP_V);
  assign near_full_o = (cnt_q == NEAR_V);

endmodule

// File: rtl/agp_rq_seq.sv
module agp_rq_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic job_busy_i,
  input  logic job_last_i,
  input  logic cap_full_i,
  input  logic cap_near_i,
  input  logic start_i,
  output logic req_n_o,
  output logic pipe_n_o,
  output logic issue_o
);
  import agp_rq_pkg::*;

  sq_state_t state_q, state_d;
  logic      final_req;

  assign final_req = job_last_i || cap_near_i;

  always_comb begin
    state_d  = state_q;
    req_n_o  = 1'b1;
    pipe_n_o = 1'b1;
    issue_o  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (job_busy_i && !cap_full_i) state_d = SQ_REQ;
      end
      SQ_REQ: begin
        req_n_o = 1'b0;
        if (start_i) state_d = SQ_ISSUE;
      end
      SQ_ISSUE: begin
        pipe_n_o = 1'b0;
        issue_o  = 1'b1;
        req_n_o  = final_req;
        if (final_req) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/agp_rd_issuer.sv
module agp_rd_issuer #(
  parameter int MAX_OUT     = 4,
  parameter int BYTES_W     = 9,
  parameter int PIECE_BYTES = 32,
  parameter int SPLIT_ABOVE = 64,
  parameter int CNT_W       = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [31:3]        rd_dw_addr,
  input  logic [BYTES_W-1:0] rd_bytes,
  input  logic               rd_hi_pri,
  output logic               bus_req_n,
  input  logic               gnt_n,
  input  logic [2:0]         st,
  output logic               pipe_n,
  output logic [31:0]        ad,
  output logic [3:0]         cbe_n,
  input  logic               reply_done,
  output logic [CNT_W-1:0]   pend_cnt
);
  import agp_rq_pkg::*;

  // Named internal events, visible to the bound checker.
  logic        start_seen;
  logic        issue_fire;
  logic        job_busy;
  logic [31:3] cur_addr;
  logic [2:0]  cur_len;
  logic        cur_last;
  logic        cap_full;
  logic        cap_near;

  assign start_seen = !gnt_n && (st == ST_START);

  agp_rq_split #(
    .BYTES_W     (BYTES_W),
    .PIECE_BYTES (PIECE_BYTES),
    .SPLIT_ABOVE (SPLIT_ABOVE)
  ) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_i      (rd_valid),
    .addr_i     (rd_dw_addr),
    .bytes_i    (rd_bytes),
    .adv_i      (issue_fire),
    .busy_o     (job_busy),
    .cur_addr_o (cur_addr),
    .cur_len_o  (cur_len),
    .cur_last_o (cur_last)
  );

  agp_rq_credit #(
    .MAX_OUT (MAX_OUT),
    .CNT_W   (CNT_W)
  ) u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_i       (issue_fire),
    .dec_i       (reply_done),
    .cnt_o       (pend_cnt),
    .full_o      (cap_full),
    .near_full_o (cap_near)
  );

  agp_rq_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .job_busy_i (job_busy),
    .job_last_i (cur_last),
    .cap_full_i (cap_full),
    .cap_near_i (cap_near),
    .start_i    (start_seen),
    .req_n_o    (bus_req_n),
    .pipe_n_o   (pipe_n),
    .issue_o    (issue_fire)
  );

  assign rd_ready = !job_busy;
  assign ad       = issue_fire ? {cur_addr, cur_len} : 32'h0;
  assign cbe_n    = issue_fire ? ~rd_cmd(rd_hi_pri) : 4'hF;

endmodule

// File: rtl/agp_rd_issuer_chk.sv
module agp_rd_issuer_chk #(
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req_n,
  input logic             pipe_n,
  input logic [3:0]       cbe_n,
  input logic             reply_done,
  input logic [CNT_W-1:0] pend_cnt,
  input logic             start_seen
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(MAX_OUT);

  AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= CAP_V); // R9
  AST_NO_ISSUE_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_n |-> pend_cnt < CAP_V); // R9
  AST_ISSUE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_n && pipe_n && start_seen) |=> !pipe_n); // R3
  AST_PIPE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pipe_n) |-> $past(start_seen)); // R3
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_n |-> (cbe_n == 4'hF || cbe_n == 4'hB)); // R4
  AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_n |-> cbe_n == 4'hF); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0 && reply_done && pipe_n) |=> pend_cnt == '0); // R10
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_n && !reply_done) |=> pend_cnt == CNT_W'($past(pend_cnt) + 1'b1)); // R8

endmodule

bind agp_rd_issuer agp_rd_issuer_chk #(
  .MAX_OUT (MAX_OUT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req_n  (bus_req_n),
  .pipe_n     (pipe_n),
  .cbe_n      (cbe_n),
  .reply_done (reply_done),
  .pend_cnt   (pend_cnt),
  .start_seen (start_seen)
);

// File: tb/sim_agp_rd_issuer.sv
module sim_agp_rd_issuer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [31:3] rd_dw_addr = '0;
  logic [8:0]  rd_bytes = '0;
  logic        rd_hi_pri = 1'b0;
  logic        bus_req_n;
  logic        gnt_n;
  logic [2:0]  st;
  logic        pipe_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        reply_done = 1'b0;
  logic [2:0]  pend_cnt;

  logic        arb_en = 1'b0;
  logic        arb_gnt_n = 1'b1;
  logic [2:0]  arb_st = 3'b000;
  logic        man_gnt_n = 1'b1;
  logic [2:0]  man_st = 3'b000;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mon_ad   [64];
  logic [3:0]  mon_cbe  [64];
  logic        mon_last [64];
  int          mon_n = 0;

  always #5 clk = ~clk;

  assign gnt_n = arb_en ? arb_gnt_n : man_gnt_n;
  assign st    = arb_en ? arb_st    : man_st;

  agp_rd_issuer u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_dw_addr(rd_dw_addr), .rd_bytes(rd_bytes), .rd_hi_pri(rd_hi_pri),
    .bus_req_n(bus_req_n), .gnt_n(gnt_n), .st(st), .pipe_n(pipe_n),
    .ad(ad), .cbe_n(cbe_n), .reply_done(reply_done), .pend_cnt(pend_cnt)
  );

  // Arbiter model: start grant on request, withdrawn on the pipe strobe.
  always @(negedge clk) begin
    if (!arb_en) begin
      arb_gnt_n <= 1'b1; arb_st <= 3'b000;
    end else if (!arb_gnt_n && !pipe_n) begin
      arb_gnt_n <= 1'b1; arb_st <= 3'b000;
    end else if (arb_gnt_n && !bus_req_n && pipe_n) begin
      arb_gnt_n <= 1'b0; arb_st <= 3'b111;
    end
  end

  // Request monitor.
  always @(negedge clk) begin
    if (rst_n && !pipe_n && mon_n < 64) begin
      mon_ad[mon_n]   <= ad;
      mon_cbe[mon_n]  <= cbe_n;
      mon_last[mon_n] <= bus_req_n;
      mon_n           <= mon_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic offer(input logic [31:0] a, input int nb, input logic hi);
    @(negedge clk);
    chk(rd_ready == 1'b1, "R1", {31'd0, rd_ready}, 32'd1);
    rd_dw_addr = a[31:3]; rd_bytes = 9'(nb); rd_hi_pri = hi; rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && pend_cnt != 0; k++) begin
      reply_done = 1'b1;
      @(negedge clk);
      reply_done = 1'b0;
      @(negedge clk);
    end
    chk(pend_cnt == 3'd0, "R8", {29'd0, pend_cnt}, 32'd0);
  endtask

  // Stimulus table: address, byte count, priority, expected request count.
  typedef struct packed {
    logic [31:0] a;
    logic [15:0] nb;
    logic        hi;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h1000_0008, 16'd8,   1'b0, 8'd1},
    '{32'h2000_0040, 16'd64,  1'b1, 8'd1},
    '{32'h0000_1010, 16'd24,  1'b0, 8'd1},
    '{32'h3000_0000, 16'd96,  1'b1, 8'd3},
    '{32'h4000_0100, 16'd72,  1'b0, 8'd3},
    '{32'h5000_0000, 16'd256, 1'b1, 8'd8}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R1, R4, R8)
    chk(rd_ready == 1'b1,  "R1", {31'd0, rd_ready}, 32'd1);
    chk(bus_req_n == 1'b1, "R2", {31'd0, bus_req_n}, 32'd1);
    chk(pipe_n == 1'b1,    "R4", {31'd0, pipe_n}, 32'd1);
    chk(ad == 32'd0 && cbe_n == 4'hF, "R4", ad, 32'd0);
    chk(pend_cnt == 3'd0,  "R8", {29'd0, pend_cnt}, 32'd0);

    // R10: completion at zero is ignored
    reply_done = 1'b1; @(negedge clk); reply_done = 1'b0; @(negedge clk);
    chk(pend_cnt == 3'd0, "R10", {29'd0, pend_cnt}, 32'd0);

    // R2/R3: manual grant, wrong status then start
    begin
      int b;
      b = mon_n;
      offer(32'h0000_2000, 8, 1'b0);
      chk(bus_req_n == 1'b1 && rd_ready == 1'b0, "R2", {31'd0, bus_req_n}, 32'd1);
      @(negedge clk);
      chk(bus_req_n == 1'b0, "R2", {31'd0, bus_req_n}, 32'd0);
      man_gnt_n = 1'b0; man_st = 3'b110;
      repeat (2) @(negedge clk);
      chk(pipe_n == 1'b1, "R3", {31'd0, pipe_n}, 32'd1);
      man_st = 3'b111;
      @(negedge clk);
      chk(pipe_n == 1'b0, "R3", {31'd0, pipe_n}, 32'd0);
      chk(ad == 32'h0000_2000 && cbe_n == 4'hF, "R4", ad, 32'h0000_2000);
      chk(bus_req_n == 1'b1, "R5", {31'd0, bus_req_n}, 32'd1);
      man_gnt_n = 1'b1; man_st = 3'b000;
      @(negedge clk);
      chk(pipe_n == 1'b1 && pend_cnt == 3'd1, "R8", {29'd0, pend_cnt}, 32'd1);
      chk(rd_ready == 1'b1, "R1", {31'd0, rd_ready}, 32'd1);
      drain();
    end

    // Table walk with arbiter model
    arb_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      int b, dones, nexp, off, rem, p;
      logic [31:0] ea;
      b = mon_n; dones = 0; nexp = int'(VECS[v].n);
      offer(VECS[v].a, int'(VECS[v].nb), VECS[v].hi);
      for (int k = 0; k < 400 && (mon_n - b) < nexp; k++) begin
        @(negedge clk);
        reply_done = 1'b0;
        if (pend_cnt == 3'd4) begin reply_done = 1'b1; dones++; end
      end
      @(negedge clk); reply_done = 1'b0;
      repeat (6) @(negedge clk);
      chk(mon_n - b == nexp, "R6", 32'(mon_n - b), 32'(nexp));
      chk(int'(pend_cnt) == nexp - dones, "R8", {29'd0, pend_cnt}, 32'(nexp - dones));
      off = 0; rem = int'(VECS[v].nb);
      for (int i = 0; i < nexp && i < 64; i++) begin
        p = (VECS[v].nb > 16'd64 && rem > 32) ? 32 : rem;
        ea = ((VECS[v].a & 32'hFFFF_FFF8) + 32'(off)) | 32'((p / 8) - 1);
        chk(mon_ad[b + i] == ea, "R6", mon_ad[b + i], ea);
        chk(mon_cbe[b + i] == (VECS[v].hi ? 4'hB : 4'hF), "R7",
            {28'd0, mon_cbe[b + i]}, VECS[v].hi ? 32'hB : 32'hF);
        off += p; rem -= p;
      end
      chk(mon_last[b + nexp - 1] == 1'b1, "R5", {31'd0, mon_last[b + nexp - 1]}, 32'd1);
      drain();
    end

    // R9: cap with silent completions, then one-by-one release
    begin
      int b;
      b = mon_n;
      offer(32'h6000_0000, 256, 1'b0);
      repeat (30) @(negedge clk);
      chk(mon_n - b == 4, "R9", 32'(mon_n - b), 32'd4);
      chk(pend_cnt == 3'd4, "R9", {29'd0, pend_cnt}, 32'd4);
      chk(mon_last[b + 3] == 1'b1 && mon_last[b + 2] == 1'b0, "R5",
          {30'd0, mon_last[b + 3], mon_last[b + 2]}, 32'd2);
      chk(bus_req_n == 1'b1 && pipe_n == 1'b1, "R9", {30'd0, bus_req_n, pipe_n}, 32'd3);
      reply_done = 1'b1; @(negedge clk); reply_done = 1'b0;
      repeat (10) @(negedge clk);
      chk(mon_n - b == 5, "R9", 32'(mon_n - b), 32'd5);
      chk(pend_cnt == 3'd4 && mon_last[b + 4] == 1'b1, "R9", {29'd0, pend_cnt}, 32'd4);
      chk(mon_ad[b + 4] == 32'h6000_0083, "R6", mon_ad[b + 4], 32'h6000_0083);
      for (int k = 0; k < 200 && (mon_n - b) < 8; k++) begin
        @(negedge clk);
        reply_done = 1'b0;
        if (pend_cnt == 3'd4) reply_done = 1'b1;
      end
      @(negedge clk); reply_done = 1'b0;
      repeat (6) @(negedge clk);
      chk(mon_n - b == 8 && rd_ready == 1'b1, "R1", 32'(mon_n - b), 32'd8);
      drain();
      reply_done = 1'b1; @(negedge clk); reply_done = 1'b0; @(negedge clk);
      chk(pend_cnt == 3'd0, "R10", {29'd0, pend_cnt}, 32'd0);
    end

    summary();
    $finish;
  end

endmodule